// File: doc/BRIEF.md
# Low-Address Protection and Prefix Unit

This block sits on the real-address path of a processor's storage access pipeline. Each request carries a real address, an access kind and the current protection-enable control. The block does two things in one step. It checks whether a store hits one of the two protected 512-byte windows at the bottom of storage. It also relocates the address through the prefix register: the first 8 KB of real storage is exchanged with the 8 KB area that the prefix points at. The result is an absolute address and, when needed, an exception code for the handler.

Whether the absolute address exists in the memory map is decided outside the block. The mapped address is presented combinationally on `lookup_addr`. The caller answers on `lookup_ok` in the same cycle. A negative answer turns the request into an addressing exception. All results are registered and appear one cycle after the request, together with a one-cycle `done` pulse.

The block hints to its translation cache that the page must not be cached as writable whenever that page holds a protected window. The cache can then catch any later store to the window. Protection is checked before the address lookup, so a protection exception hides an addressing exception.

Top module: `lap_prefix_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `done`, `prot_exc`, `addr_exc`, `wr_inval`, `abs_addr` and `tec` are all zero, and requests made during reset are ignored.
- R2: A request with `req_valid` high gives `done` high on the next cycle only. Without a request, `done` is low and every other output holds its last value.
- R3: A store (`req_kind` = 2'b01) to an address in 0..511 or 4096..4607 while `prot_en` is 1 sets `prot_exc`. Addresses 512..4095 and from 4608 upward do not set it. A load (2'b00), a fetch (2'b10) or the read-kind code 2'b11 never sets it, and nothing sets it when `prot_en` is 0.
- R4: `wr_inval` is set for any access kind when `prot_en` is 1 and the address lies in 0..8191, which is the two 4 KB pages that hold the windows. Otherwise it is clear.
- R5: On a protection exception, `tec` is the address with bits 11:0 cleared, OR 0x400 OR 0x80. `addr_exc` stays clear even when `lookup_ok` is low.
- R6: A real address below 0x2000 maps to the real address plus the prefix.
- R7: An address from the prefix up to, but not including, prefix+0x2000 maps to the address minus the prefix. Every other address is passed through unchanged.
- R8: Bits 12:0 of `prefix_base` are ignored, so the prefix is always 8 KB aligned.
- R9: `lookup_addr` shows the mapped address in the request cycle, and `lookup_ok` is sampled in that cycle. Without a protection exception, a low `lookup_ok` sets `addr_exc` and forces `tec` to zero.
- R10: A request with no exception reports `tec` as the page-aligned address OR 0x400 for a store, or OR 0x800 for a load, a fetch or the code 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | AW | Real address of the access |
| req_kind | input | 2 | 00 load, 01 store, 10 fetch, 11 treated as a read |
| prot_en | input | 1 | Low-address protection enable |
| prefix_base | input | AW | Prefix register value; bits 12:0 are ignored |
| lookup_addr | output | AW | Combinational mapped address, sent for the existence check |
| lookup_ok | input | 1 | Mapped address exists (same cycle as the request) |
| done | output | 1 | One-cycle result pulse |
| abs_addr | output | AW | Registered absolute address |
| prot_exc | output | 1 | Protection exception |
| addr_exc | output | 1 | Addressing exception |
| wr_inval | output | 1 | Page must not be cached as writable |
| tec | output | AW | Translation exception code |

## Verification
The hardest cases to reach are at the edges of the prefix area when the prefix is not zero. An address one below the prefix, exactly at it, at prefix+0x1FFF and at prefix+0x2000 must each land in the right region. Random 64-bit addresses almost never hit them. The stimulus therefore picks addresses near chosen boundaries: these prefix edges, 511/512, 4095/4096, 4607/4608 and 8191/8192. It adds garbage to the low prefix bits and crosses all of them with every access kind, both `prot_en` values and both lookup answers, so that the exception priority is also reached.

// File: rtl/lap_pkg.sv
package lap_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_READX = 2'b11
  } acc_kind_e;

  // exception-code marker bits (low 12 bits of the code)
  localparam logic [11:0] TEC_FS_STORE = 12'h400;
  localparam logic [11:0] TEC_FS_READ  = 12'h800;
  localparam logic [11:0] TEC_LAP_MARK = 12'h080;
endpackage

// File: rtl/lap_window_check.sv
module lap_window_check #(
  parameter int AW        = 64,
  parameter int PAGE_BITS = 12,
  parameter int WIN_BITS  = 9
) (
  input  logic [AW-1:0] addr,
  input  logic          en,
  output logic          page_low,
  output logic          addr_low
);
  localparam int PAIR_BITS = PAGE_BITS + 1;

  logic in_first_pages;
  logic in_window;

  // pages 0 and 1: everything above the page pair is zero
  assign in_first_pages = (addr[AW-1:PAIR_BITS] == '0);
  // first WIN bytes of either page
  assign in_window      = (addr[PAGE_BITS-1:WIN_BITS] == '0);

  assign page_low = en && in_first_pages;
  assign addr_low = en && in_first_pages && in_window;
endmodule

// File: rtl/prefix_swap.sv
module prefix_swap #(
  parameter int AW        = 64,
  parameter int AREA_BITS = 13
) (
  input  logic [AW-1:0] real_addr,
  input  logic [AW-1:0] prefix_raw,
  output logic [AW-1:0] abs_addr
);
  logic [AW-AREA_BITS-1:0] area_hi;
  logic [AW-AREA_BITS-1:0] pfx_hi;
  logic [AREA_BITS-1:0]    area_off;
  logic                    hit_zero_area;
  logic                    hit_pfx_area;

  assign area_hi  = real_addr[AW-1:AREA_BITS];
  assign area_off = real_addr[AREA_BITS-1:0];
  assign pfx_hi   = prefix_raw[AW-1:AREA_BITS];

  // prefix is area aligned, so range tests reduce to compares of the upper bits
  assign hit_zero_area = (area_hi == '0);
  assign hit_pfx_area  = (area_hi == pfx_hi);

  always_comb begin
    if (hit_zero_area)
      abs_addr = {pfx_hi, area_off};
    else if (hit_pfx_area)
      abs_addr = {{(AW-AREA_BITS){1'b0}}, area_off};
    else
      abs_addr = real_addr;
  end
endmodule

// File: rtl/tec_builder.sv
module tec_builder
  import lap_pkg::*;
#(
  parameter int AW        = 64,
  parameter int PAGE_BITS = 12
) (
  input  logic [AW-1:0] addr,
  input  logic          is_store,
  input  logic          lap_hit,
  input  logic          exists,
  output logic          prot_fault,
  output logic          addr_fault,
  output logic [AW-1:0] code
);
  logic [AW-1:0] page_base;
  logic [AW-1:0] fs_bits;

  assign page_base = {addr[AW-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
  assign fs_bits   = AW'(is_store ? TEC_FS_STORE : TEC_FS_READ);

  assign prot_fault = lap_hit && is_store;
  assign addr_fault = !prot_fault && !exists;

  always_comb begin
    if (prot_fault)
      code = page_base | AW'(TEC_FS_STORE) | AW'(TEC_LAP_MARK);
    else if (addr_fault)
      code = '0;
    else
      code = page_base | fs_bits;
  end
endmodule

// File: rtl/lap_prefix_unit.sv
module lap_prefix_unit
  import lap_pkg::*;
#(
  parameter int AW        = 64,
  parameter int PAGE_BITS = 12,
  parameter int WIN_BITS  = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_kind,
  input  logic          prot_en,
  input  logic [AW-1:0] prefix_base,
  output logic [AW-1:0] lookup_addr,
  input  logic          lookup_ok,
  output logic          done,
  output logic [AW-1:0] abs_addr,
  output logic          prot_exc,
  output logic          addr_exc,
  output logic          wr_inval,
  output logic [AW-1:0] tec
);
  localparam int AREA_BITS = PAGE_BITS + 1;

  logic          page_low_c;
  logic          addr_low_c;
  logic          is_store_c;
  logic          prot_c;
  logic          aexc_c;
  logic [AW-1:0] code_c;
  logic [AW-1:0] mapped_c;

  assign is_store_c = (acc_kind_e'(req_kind) == ACC_STORE);

  lap_window_check #(.AW(AW), .PAGE_BITS(PAGE_BITS), .WIN_BITS(WIN_BITS)) u_win (
    .addr     (req_addr),
    .en       (prot_en),
    .page_low (page_low_c),
    .addr_low (addr_low_c)
  );

  prefix_swap #(.AW(AW), .AREA_BITS(AREA_BITS)) u_swap (
    .real_addr  (req_addr),
    .prefix_raw (prefix_base),
    .abs_addr   (mapped_c)
  );

  tec_builder #(.AW(AW), .PAGE_BITS(PAGE_BITS)) u_tec (
    .addr       (req_addr),
    .is_store   (is_store_c),
    .lap_hit    (addr_low_c),
    .exists     (lookup_ok),
    .prot_fault (prot_c),
    .addr_fault (aexc_c),
    .code       (code_c)
  );

  assign lookup_addr = mapped_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      abs_addr <= '0;
      prot_exc <= 1'b0;
      addr_exc <= 1'b0;
      wr_inval <= 1'b0;
      tec      <= '0;
    end else begin
      done <= req_valid;
      if (req_valid) begin
        abs_addr <= mapped_c;
        prot_exc <= prot_c;
        addr_exc <= aexc_c;
        wr_inval <= page_low_c;
        tec      <= code_c;
      end
    end
  end
endmodule

// File: rtl/lap_prefix_unit_sva.sv
module lap_prefix_unit_sva #(
  parameter int AW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          prot_en,
  input logic          done,
  input logic [AW-1:0] abs_addr,
  input logic          prot_exc,
  input logic          addr_exc,
  input logic          wr_inval,
  input logic [AW-1:0] tec
);
  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> done); // R2
  AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !done); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(abs_addr) && $stable(tec)); // R2
  AST_LAP_CODE: assert property (@(posedge clk) disable iff (rst)
    prot_exc |-> tec[11:0] == 12'h480); // R5
  AST_LAP_HINT: assert property (@(posedge clk) disable iff (rst)
    prot_exc |-> wr_inval); // R4
  AST_EXC_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(prot_exc && addr_exc)); // R5
  AST_ADDR_CODE_ZERO: assert property (@(posedge clk) disable iff (rst)
    addr_exc |-> tec == '0); // R9
  AST_OFF_NO_LAP: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !prot_en) |=> !prot_exc && !wr_inval); // R3
endmodule

bind lap_prefix_unit lap_prefix_unit_sva #(.AW(AW)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .prot_en   (prot_en),
  .done      (done),
  .abs_addr  (abs_addr),
  .prot_exc  (prot_exc),
  .addr_exc  (addr_exc),
  .wr_inval  (wr_inval),
  .tec       (tec)
);

// File: tb/lap_prefix_unit_test.sv
module lap_prefix_unit_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst;
  logic        req_valid;
  logic [63:0] req_addr;
  logic [1:0]  req_kind;
  logic        prot_en;
  logic [63:0] prefix_base;
  logic [63:0] lookup_addr;
  logic        lookup_ok;
  logic        done;
  logic [63:0] abs_addr;
  logic        prot_exc;
  logic        addr_exc;
  logic        wr_inval;
  logic [63:0] tec;

  lap_prefix_unit uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_kind(req_kind), .prot_en(prot_en), .prefix_base(prefix_base),
    .lookup_addr(lookup_addr), .lookup_ok(lookup_ok), .done(done),
    .abs_addr(abs_addr), .prot_exc(prot_exc), .addr_exc(addr_exc),
    .wr_inval(wr_inval), .tec(tec)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic        e_done, e_prot, e_aexc, e_inval;
  logic [63:0] e_abs, e_tec;
  string       e_map_tag, e_tec_tag;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit m_low(input logic [63:0] a);
    return (a <= 64'd511) || (a >= 64'd4096 && a <= 64'd4607);
  endfunction

  function automatic logic [63:0] m_map(input logic [63:0] a, input logic [63:0] p);
    logic [63:0] pa;
    pa = p & ~64'h1FFF;
    if (a < 64'h2000) return a + pa;
    if (a >= pa && a < pa + 64'h2000) return a - pa;
    return a;
  endfunction

  function automatic string m_tag(input logic [63:0] a, input logic [63:0] p);
    logic [63:0] pa;
    pa = p & ~64'h1FFF;
    if (a < 64'h2000) return "R6/R8 abs_addr";
    if (a >= pa && a < pa + 64'h2000) return "R7/R8 abs_addr";
    return "R7 abs_addr passthrough";
  endfunction

  task automatic compare();
    chk("R2 done", 64'(done), 64'(e_done));
    chk(e_map_tag, abs_addr, e_abs);
    chk("R3 prot_exc", 64'(prot_exc), 64'(e_prot));
    chk("R4 wr_inval", 64'(wr_inval), 64'(e_inval));
    chk("R9 addr_exc", 64'(addr_exc), 64'(e_aexc));
    chk(e_tec_tag, tec, e_tec);
  endtask

  task automatic step(input bit v, input logic [63:0] a, input logic [1:0] k,
                      input bit en, input logic [63:0] p, input bit ok);
    bit st, pr, ae;
    @(negedge clk);
    compare();
    req_valid = v; req_addr = a; req_kind = k; prot_en = en;
    prefix_base = p; lookup_ok = ok;
    #1;
    if (v) chk("R9 lookup_addr", lookup_addr, m_map(a, p));
    e_done = v;
    if (v) begin
      st = (k == 2'b01);
      pr = en && st && m_low(a);
      ae = !pr && !ok;
      e_abs = m_map(a, p);
      e_map_tag = m_tag(a, p);
      e_prot = pr;
      e_aexc = ae;
      e_inval = en && (a < 64'h2000);
      if (pr) begin
        e_tec = (a & ~64'hFFF) | 64'h480; e_tec_tag = "R5 tec";
      end else if (ae) begin
        e_tec = 64'h0; e_tec_tag = "R9 tec";
      end else begin
        e_tec = (a & ~64'hFFF) | (st ? 64'h400 : 64'h800); e_tec_tag = "R10 tec";
      end
    end else begin
      e_map_tag = "R2 abs_addr hold";
      e_tec_tag = "R2 tec hold";
    end
  endtask

  function automatic logic [63:0] pick_addr(input int sel, input logic [63:0] pa);
    case (sel)
      0: return 64'd511;
      1: return 64'd512;
      2: return 64'd4095;
      3: return 64'd4096;
      4: return 64'd4607;
      5: return 64'd4608;
      6: return 64'd8191;
      7: return 64'd8192;
      8: return pa - 64'd1;
      9: return pa;
      10: return pa + 64'h1FFF;
      11: return pa + 64'h2000;
      12: return 64'($urandom_range(0, 8191));
      13: return pa + 64'($urandom_range(0, 8191));
      default: return {32'($urandom), 32'($urandom)} >> 4;
    endcase
  endfunction

  initial begin
    rst = 1'b1; req_valid = 1'b1; req_addr = 64'd100; req_kind = 2'b01;
    prot_en = 1'b1; prefix_base = 64'h4000; lookup_ok = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset values, request during reset ignored
    chk("R1 done", 64'(done), 64'h0);
    chk("R1 abs_addr", abs_addr, 64'h0);
    chk("R1 prot_exc", 64'(prot_exc), 64'h0);
    chk("R1 addr_exc", 64'(addr_exc), 64'h0);
    chk("R1 wr_inval", 64'(wr_inval), 64'h0);
    chk("R1 tec", tec, 64'h0);
    rst = 1'b0; req_valid = 1'b0;
    e_done = 0; e_abs = 0; e_prot = 0; e_aexc = 0; e_inval = 0; e_tec = 0;
    e_map_tag = "R1 abs_addr"; e_tec_tag = "R1 tec";

    // R3/R5: window edges with protection on, stores
    step(1, 64'd0,    2'b01, 1, 64'h10000, 1);
    step(1, 64'd511,  2'b01, 1, 64'h10000, 0);  // R5 protection wins
    step(1, 64'd512,  2'b01, 1, 64'h10000, 1);
    step(1, 64'd4095, 2'b01, 1, 64'h10000, 1);
    step(1, 64'd4096, 2'b01, 1, 64'h10000, 1);
    step(1, 64'd4607, 2'b01, 1, 64'h10000, 1);
    step(1, 64'd4608, 2'b01, 1, 64'h10000, 1);
    step(1, 64'd8191, 2'b01, 1, 64'h10000, 1);  // R4 edge
    step(1, 64'd8192, 2'b01, 1, 64'h10000, 1);
    // R3: reads and fetches never protected; protection off
    step(1, 64'd16,   2'b00, 1, 64'h10000, 1);
    step(1, 64'd16,   2'b10, 1, 64'h10000, 1);
    step(1, 64'd16,   2'b11, 1, 64'h10000, 1);
    step(1, 64'd16,   2'b01, 0, 64'h10000, 1);
    // R2: idle hold
    step(0, 64'd0, 2'b01, 1, 64'h0, 0);
    step(0, 64'd7, 2'b00, 0, 64'h0, 0);
    // R7/R8: prefix area edges, garbage in low prefix bits
    step(1, 64'h0FFFF,  2'b00, 0, 64'h11FFF, 1);
    step(1, 64'h10000,  2'b00, 0, 64'h11FFF, 1);
    step(1, 64'h11FFF,  2'b01, 0, 64'h11FFF, 1);
    step(1, 64'h12000,  2'b10, 0, 64'h11FFF, 1);
    // R9/R10: addressing exception and plain codes
    step(1, 64'hABCDE123, 2'b01, 1, 64'h10000, 0);
    step(1, 64'hABCDE123, 2'b10, 1, 64'h10000, 1);
    step(1, 64'h1234,     2'b00, 1, 64'h0,     1);  // R6 zero prefix

    for (int i = 0; i < 3000; i++) begin
      logic [63:0] p;
      logic [63:0] pa;
      p  = {20'h0, 32'($urandom), 12'($urandom)};
      if ($urandom_range(0, 15) == 0) p = 64'h0;
      pa = p & ~64'h1FFF;
      step(($urandom_range(0, 5) != 0), pick_addr($urandom_range(0, 15), pa),
           2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), p,
           ($urandom_range(0, 7) != 0));
    end
    step(0, 64'h0, 2'b00, 0, 64'h0, 1);
    @(negedge clk);
    compare();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule